// File: doc/BRIEF.md
# Byte-Lane Set/Clear Control Register Bank

This block holds a small bank of 32-bit control registers that software updates without a read-modify-write sequence. Every byte of a write carries its own polarity: the top bit of the byte is the value, and the lower seven bits pick which register bits in that byte take the value. Bits whose select bit is zero keep their old state. A single write can therefore set some bits in one byte and clear others in a different byte, with no effect on anything else.

The bank sits on a simple register bus with an address, write data, byte enables, a write strobe and read data. Five registers live at fixed byte offsets. Each register implements only a subset of its bits, and the stored contents drive straight out as control outputs. Reads return the stored value with no side effect. Unmapped addresses read as zero and ignore writes.

Top module: `cmdreg_bank`

## Requirements
- R1: After reset every register reads 0 and every control output is 0.
- R2: In an enabled byte lane with the value bit (bit 7 of the byte) at 1, each register bit whose select bit (bits 6..0 of that byte) is 1 becomes 1. For example, 8'h9A in lane 0 sets bits 1, 3 and 4.
- R3: In an enabled byte lane with the value bit at 0, each register bit whose select bit is 1 becomes 0. For example, 8'h1A in lane 0 clears bits 1, 3 and 4.
- R4: In an enabled lane, register bits whose select bit is 0 keep their previous value.
- R5: A lane whose byte enable is 0 leaves all eight register bits of that lane unchanged, whatever data it carries.
- R6: The four lanes act independently in one write, and each lane uses its own value bit.
- R7: Bits outside the implemented mask always read 0. This includes the value-bit positions 31, 23, 15 and 7. The masks are 0x1F7F7F1F at 0x40, 0x000F0F7F at 0x48, 0x3F7F3F7F at 0x50, 0x0F7F3F7F at 0x54 and 0x0000001B at 0x64.
- R8: A write reaches only the register at its address. An unmapped address reads 0 and its writes change no register.
- R9: A read changes no state. Each control output slice (slice k is register k, in offset order 0x40, 0x48, 0x50, 0x54, 0x64) equals the value that register reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, four set/clear lanes |
| bus_be | input | 4 | Byte-lane enables |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ctl_bits | output | 160 | Stored register contents, 32 bits per register |

## Verification
If a lane applies the wrong polarity, or touches bits it did not select, the fault shows on the next read of that register. It also shows on the matching control output slice one cycle after the write edge. If address decode is wrong, a write lands in a neighbouring register, and a later read of that neighbour shows stray bits. A leak into an unimplemented or value-bit position shows as a nonzero bit outside the mask on the first readback.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    localparam int CMD_DW    = 32;
    localparam int CMD_AW    = 8;
    localparam int NUM_REGS  = 5;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = CMD_DW / LANE_W;

    localparam logic [CMD_AW-1:0] REG_OFFS [NUM_REGS] =
        '{8'h40, 8'h48, 8'h50, 8'h54, 8'h64};
    localparam logic [CMD_DW-1:0] REG_MASKS [NUM_REGS] =
        '{32'h1F7F7F1F, 32'h000F0F7F, 32'h3F7F3F7F, 32'h0F7F3F7F, 32'h0000001B};

    typedef struct packed {
        logic [CMD_DW-1:0] bits;
    } cell_state_t;
endpackage

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
    import cmdreg_pkg::*;
(
    input  logic [CMD_AW-1:0]   addr,
    output logic [NUM_REGS-1:0] hit
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_cmp
        assign hit[k] = (addr == REG_OFFS[k]);
    end
endmodule

// File: rtl/cmdreg_cell.sv
module cmdreg_cell
    import cmdreg_pkg::*;
#(
    parameter logic [CMD_DW-1:0] IMPL_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [CMD_DW-1:0]    wdata,
    output logic [CMD_DW-1:0]    bits_o
);
    localparam logic [CMD_DW-1:0] VAL_POS    = {NUM_LANES{8'h80}};
    localparam logic [CMD_DW-1:0] STORE_MASK = IMPL_MASK & ~VAL_POS;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            for (int b = 0; b < NUM_LANES; b++) begin
                if (lane_en[b]) begin
                    for (int i = 0; i < LANE_W - 1; i++) begin
                        if (wdata[b*LANE_W + i])
                            st_d.bits[b*LANE_W + i] = wdata[b*LANE_W + LANE_W - 1];
                    end
                end
            end
        end
        st_d.bits = st_d.bits & STORE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_o = st_q.bits;

    for (genvar b = 0; b < NUM_LANES; b++) begin : g_chk
        // R2: selected implemented bits go to 1 when the value bit is 1
        assert_lane_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && lane_en[b] && wdata[b*LANE_W+7]) |=>
            ((bits_o[b*LANE_W +: 7] & $past(wdata[b*LANE_W +: 7]) & STORE_MASK[b*LANE_W +: 7])
              == ($past(wdata[b*LANE_W +: 7]) & STORE_MASK[b*LANE_W +: 7])));
        // R3: selected bits go to 0 when the value bit is 0
        assert_lane_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && lane_en[b] && !wdata[b*LANE_W+7]) |=>
            ((bits_o[b*LANE_W +: 7] & $past(wdata[b*LANE_W +: 7])) == 7'd0));
        // R4: unselected bits in an enabled lane hold
        assert_unselected_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && lane_en[b]) |=>
            ((bits_o[b*LANE_W +: 7] & ~$past(wdata[b*LANE_W +: 7]))
              == ($past(bits_o[b*LANE_W +: 7]) & ~$past(wdata[b*LANE_W +: 7]))));
        // R5: a disabled lane (or no write here) holds all its bits
        assert_lane_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_hit || !lane_en[b]) |=>
            (bits_o[b*LANE_W +: LANE_W] == $past(bits_o[b*LANE_W +: LANE_W])));
    end
endmodule

// File: rtl/cmdreg_rdmux.sv
module cmdreg_rdmux
    import cmdreg_pkg::*;
(
    input  logic [NUM_REGS-1:0]        hit,
    input  logic [NUM_REGS*CMD_DW-1:0] regs_flat,
    output logic [CMD_DW-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit[k]) rdata = rdata | regs_flat[k*CMD_DW +: CMD_DW];
        end
    end
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
    import cmdreg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CMD_AW-1:0]           bus_addr,
    input  logic [CMD_DW-1:0]           bus_wdata,
    input  logic [NUM_LANES-1:0]        bus_be,
    input  logic                        bus_we,
    output logic [CMD_DW-1:0]           bus_rdata,
    output logic [NUM_REGS*CMD_DW-1:0]  ctl_bits
);
    logic [NUM_REGS-1:0] hit;

    cmdreg_decode u_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        cmdreg_cell #(.IMPL_MASK(REG_MASKS[k])) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (bus_we && hit[k]),
            .lane_en (bus_be),
            .wdata   (bus_wdata),
            .bits_o  (ctl_bits[k*CMD_DW +: CMD_DW])
        );

        // R7: readback never shows bits outside the implemented mask
        assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |-> ((bus_rdata & ~REG_MASKS[k]) == '0));
        // R9: readback equals the control output of the addressed register
        assert_read_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |-> (bus_rdata == ctl_bits[k*CMD_DW +: CMD_DW]));
    end

    cmdreg_rdmux u_rdmux (
        .hit       (hit),
        .regs_flat (ctl_bits),
        .rdata     (bus_rdata)
    );

    // R8: at most one register answers an address; unmapped reads are zero
    assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/test_cmdreg_bank.sv
module test_cmdreg_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [3:0]   bus_be = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_rdata;
    logic [159:0] ctl_bits;

    always #4 clk = ~clk;

    cmdreg_bank i_cmdreg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_we(bus_we), .bus_rdata(bus_rdata), .ctl_bits(ctl_bits)
    );

    typedef struct {
        logic [31:0] exp;
        int          idx;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic        chk_req = 1'b0;
    int          checks = 0;
    int          fails  = 0;

    logic [7:0]  offs  [5] = '{8'h40, 8'h48, 8'h50, 8'h54, 8'h64};
    logic [31:0] masks [5] = '{32'h1F7F7F1F, 32'h000F0F7F, 32'h3F7F3F7F, 32'h0F7F3F7F, 32'h0000001B};
    logic [31:0] mdl   [5] = '{default: '0};

    function automatic int idx_of(input logic [7:0] a);
        for (int k = 0; k < 5; k++) if (offs[k] == a) return k;
        return -1;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        int k;
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_be = '0;
        k = idx_of(a);
        if (k >= 0) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) begin
                    for (int i = 0; i < 7; i++) begin
                        if (d[8*b+i]) mdl[k][8*b+i] = d[8*b+7];
                    end
                end
            end
            mdl[k] = mdl[k] & masks[k];
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        item_t it;
        int k;
        k = idx_of(a);
        @(posedge clk); #1;
        bus_addr = a;
        it.idx = k;
        it.exp = (k >= 0) ? mdl[k] : 32'h0;
        it.tag = tag;
        sb_q.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic rd_all(input string tag);
        for (int k = 0; k < 5; k++) rd(offs[k], tag);
    endtask

    // monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        if (chk_req && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                fails++;
                $display("FAIL %s addr=%h rdata actual=%h expected=%h", it.tag, bus_addr, bus_rdata, it.exp);
            end
            if (it.idx >= 0) begin
                checks++;
                if (ctl_bits[it.idx*32 +: 32] !== it.exp) begin
                    fails++;
                    $display("FAIL R9 %s ctl slice %0d actual=%h expected=%h",
                             it.tag, it.idx, ctl_bits[it.idx*32 +: 32], it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_all("R1 reset");
        // R2: set bits 1,3,4 in lane 0
        wr(8'h40, 32'h0000009A, 4'b0001);
        rd(8'h40, "R2 set lane0");
        // R3/R4: set low five, then clear 1,3,4; bits 0 and 2 stay
        wr(8'h40, 32'h0000009F, 4'b0001);
        wr(8'h40, 32'h0000001A, 4'b0001);
        rd(8'h40, "R3 R4 clear lane0");
        // R5: all lanes disabled
        wr(8'h40, 32'hFFFFFFFF, 4'b0000);
        rd(8'h40, "R5 no lanes");
        // R5: only lane 1 enabled
        wr(8'h40, 32'hFFFFFFFF, 4'b0010);
        rd(8'h40, "R5 lane1 only");
        // R6: mixed polarity across lanes
        wr(8'h50, 32'h7F7F7F7F | 32'h80008080, 4'b1111);
        rd(8'h50, "R6 fill");
        wr(8'h50, 32'h81_05_FF_00, 4'b1111);
        rd(8'h50, "R6 mixed lanes");
        wr(8'h50, 32'h00_80_12_93, 4'b1111);
        rd(8'h50, "R6 second mix");
        // R7: unimplemented and value positions read 0
        wr(8'h64, 32'hFFFFFFFF, 4'b1111);
        rd(8'h64, "R7 mask 0x64");
        wr(8'h48, 32'hFFFFFFFF, 4'b1111);
        rd(8'h48, "R7 mask 0x48");
        wr(8'h54, 32'hFFFFFFFF, 4'b1111);
        rd(8'h54, "R7 mask 0x54");
        // R8: isolation and unmapped addresses
        wr(8'h48, 32'h7F7F7F7F, 4'b1111);
        rd_all("R8 isolation");
        wr(8'h44, 32'hFFFFFFFF, 4'b1111);
        wr(8'h4C, 32'hFFFFFFFF, 4'b1111);
        rd(8'h44, "R8 unmapped read");
        rd(8'h60, "R8 unmapped read");
        rd_all("R8 after unmapped write");
        // R9: repeated reads leave state unchanged
        rd(8'h54, "R9 reread");
        rd(8'h54, "R9 reread");
        rd_all("R9 final");
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule